// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Detector

This controller sits beside an SRAM-style bus with an address, an active-low chip enable, an active-low write enable and an active-low output enable. It watches chip-enable pulses for a fixed unlock sequence of six addresses. When the sequence completes, it launches a nonvolatile save (STORE) or restore (RECALL) of the array. The sixth address decides which of the two runs.

An operation runs for a fixed number of clock cycles, set by a parameter. During that time `busy` is high, every bus input is ignored, and the data drive enable is held off. When the operation finishes, `op_done` pulses for one cycle. Leaving reset counts as power-up: the block first runs an automatic RECALL, and normal access is allowed only after it ends.

A step is accepted only if the whole pulse meets three conditions: chip enable stays low for at least a minimum number of cycles, write enable stays high, and the address taken at the falling edge matches the one expected. The output enable plays no part in the sequence. Any other pulse aborts the sequence. A stray or repeated read therefore forces the unlock to begin again.

Top module: `nvsr_ctrl`

## Requirements
- R1: A sequence step is taken from one chip-enable low pulse. The address is sampled in the first cycle that `ce_n` is low, and the step is judged in the first cycle `ce_n` is high again. An operation that a pulse starts shows `busy`=1 one clock after that judging cycle. With the defaults, the five lead-in addresses are 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order.
- R2: A pulse counts only if `we_n` is 1 in every cycle that `ce_n` is 0. A pulse with `we_n` low at any point resets the sequence to its start. `oe_n` has no effect on the sequence.
- R3: When the five lead-in steps are followed by a sixth pulse at 0x0F0F, a STORE starts (`op_store`=1). When they are followed by a sixth pulse at 0x0F0E, a RECALL starts (`op_store`=0). Any other sixth address starts nothing.
- R4: A pulse whose address is not the next one expected resets the sequence. That same pulse is then checked against the first address, so a mismatching pulse at 0x0000 counts as step one.
- R5: A pulse with at least MIN_LOW low cycles is a valid step, however short of a full access it is. A shorter pulse, for example a noise glitch, aborts the sequence.
- R6: `busy` stays high for exactly STORE_CYC cycles for a STORE and RECALL_CYC cycles for a RECALL. `op_done` is high for a single cycle, the first one in which `busy` is low again.
- R7: While `busy` is high, every bus pulse is ignored, including a pulse that is still low when the operation ends. The sequence is back at its start when the operation completes.
- R8: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0, `we_n`=1 and the block is not busy. It goes to 0 no later than one clock after an operation starts.
- R9: After reset, the block is busy with a RECALL (`op_store`=0) for PWRUP_CYC cycles, then pulses `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| bus_addr | input | AW | Bus address |
| ce_n | input | 1 | Chip enable, active low; strobes each sequence step |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| busy | output | 1 | Store/recall in progress |
| op_store | output | 1 | Kind of current or last operation: 1 STORE, 0 RECALL |
| op_done | output | 1 | One-cycle pulse when an operation ends |

## Verification
Two things can fall in the same cycle: the end of an operation and the rising edge of a chip-enable pulse that began while the block was busy. The bench holds `ce_n` low through the whole power-up recall. It releases `ce_n` in the cycle after `op_done`, so the pulse is judged just as tracking resumes. The outcome is judged at the ports in two ways. First, the remaining five addresses of a STORE sequence must then start nothing. Second, a fresh full sequence must still start an operation afterwards.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;
    // Number of pulses in one unlock sequence (five lead-in plus the selector).
    localparam int unsigned SEQ_LEN = 6;
    localparam int unsigned STEP_W  = $clog2(SEQ_LEN);

    typedef enum logic {
        OP_RECALL = 1'b0,
        OP_STORE  = 1'b1
    } op_e;
endpackage

// File: rtl/nvsr_pulse_mon.sv
// Tracks one chip-enable low pulse and reports it when the pulse ends.
module nvsr_pulse_mon #(
    parameter int unsigned AW      = 13,
    parameter int unsigned MIN_LOW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          busy,
    output logic          evt,
    output logic          evt_ok,
    output logic [AW-1:0] evt_addr
);
    localparam int unsigned LW = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic          ce_prev;
        logic          armed;
        logic [LW-1:0] low_cnt;
        logic          we_good;
        logic [AW-1:0] addr;
    } mon_t;

    mon_t s_q, s_d;

    wire fall = !ce_n && s_q.ce_prev;
    wire rise = ce_n && !s_q.ce_prev;

    always_comb begin
        s_d         = s_q;
        s_d.ce_prev = ce_n;
        if (busy) begin
            s_d.armed = 1'b0;
        end else if (fall) begin
            s_d.armed   = 1'b1;
            s_d.addr    = bus_addr;
            s_d.we_good = we_n;
            s_d.low_cnt = LW'(1);
        end else if (!ce_n) begin
            s_d.we_good = s_q.we_good && we_n;
            if (s_q.low_cnt < LW'(MIN_LOW))
                s_d.low_cnt = s_q.low_cnt + LW'(1);
        end else if (rise) begin
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ce_prev: 1'b1, armed: 1'b0, low_cnt: '0, we_good: 1'b0, addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign evt      = rise && s_q.armed && !busy;
    assign evt_ok   = s_q.we_good && (s_q.low_cnt >= LW'(MIN_LOW));
    assign evt_addr = s_q.addr;

    // R5: the width counter never passes its saturation value
    p_low_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.low_cnt <= LW'(MIN_LOW));
    // R7: a pulse that began while busy is never armed
    p_no_arm_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !s_q.armed);
endmodule

// File: rtl/nvsr_seq.sv
// Step matcher for the six-address unlock sequence.
module nvsr_seq
    import nvsr_pkg::*;
#(
    parameter int unsigned               AW          = 13,
    parameter logic [4:0][AW-1:0]        LEAD_ADDR   = '0,
    parameter logic [AW-1:0]             STORE_ADDR  = '0,
    parameter logic [AW-1:0]             RECALL_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          evt_ok,
    input  logic [AW-1:0] evt_addr,
    input  logic          busy,
    output logic          go_store,
    output logic          go_recall
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

    logic [STEP_W-1:0] step_q, step_d;
    logic              is_first;

    assign is_first = (evt_addr == LEAD_ADDR[0]);

    always_comb begin
        step_d    = step_q;
        go_store  = 1'b0;
        go_recall = 1'b0;
        if (busy) begin
            step_d = '0;
        end else if (evt) begin
            if (!evt_ok) begin
                step_d = '0;
            end else if (step_q == LAST) begin
                go_store  = (evt_addr == STORE_ADDR);
                go_recall = (evt_addr == RECALL_ADDR);
                if (go_store || go_recall)
                    step_d = '0;
                else
                    step_d = is_first ? STEP_W'(1) : '0;
            end else if (evt_addr == LEAD_ADDR[step_q]) begin
                step_d = step_q + STEP_W'(1);
            end else begin
                step_d = is_first ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    // R2 / R5: a rejected pulse returns the sequence to its start
    p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !evt_ok && !busy) |=> step_q == '0);
    // R7: tracking is held at the start while an operation runs
    p_clear_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> step_q == '0);
    // R4: the step index stays within the sequence
    p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST);
    // R3: the two launch outputs never fire together
    p_one_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_store && go_recall));
endmodule

// File: rtl/nvsr_op_timer.sv
// Runs a store or recall for a fixed number of cycles; power-up recall from reset.
module nvsr_op_timer
    import nvsr_pkg::*;
#(
    parameter int unsigned CW         = 6,
    parameter int unsigned STORE_CYC  = 20,
    parameter int unsigned RECALL_CYC = 12,
    parameter int unsigned PWRUP_CYC  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_store,
    input  logic go_recall,
    output logic busy,
    output logic op_store,
    output logic op_done
);
    typedef struct packed {
        logic          busy;
        op_e           kind;
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
                t_d.done = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - CW'(1);
            end
        end else if (go_store) begin
            t_d.busy = 1'b1;
            t_d.kind = OP_STORE;
            t_d.cnt  = CW'(STORE_CYC - 1);
        end else if (go_recall) begin
            t_d.busy = 1'b1;
            t_d.kind = OP_RECALL;
            t_d.cnt  = CW'(RECALL_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{busy: 1'b1, kind: OP_RECALL, cnt: CW'(PWRUP_CYC - 1), done: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign busy     = t_q.busy;
    assign op_store = (t_q.kind == OP_STORE);
    assign op_done  = t_q.done;

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    // R6: busy only falls together with a completion pulse
    p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> op_done);
    // R7: the operation kind is frozen while busy
    p_kind_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_store));
endmodule

// File: rtl/nvsr_ctrl.sv
// Top: nonvolatile store/recall sequence detector.
module nvsr_ctrl
    import nvsr_pkg::*;
#(
    parameter int unsigned AW          = 13,
    parameter logic [AW-1:0] SEQ_A1    = 13'h0000,
    parameter logic [AW-1:0] SEQ_A2    = 13'h1555,
    parameter logic [AW-1:0] SEQ_A3    = 13'h0AAA,
    parameter logic [AW-1:0] SEQ_A4    = 13'h1FFF,
    parameter logic [AW-1:0] SEQ_A5    = 13'h10F0,
    parameter logic [AW-1:0] STORE_ADDR  = 13'h0F0F,
    parameter logic [AW-1:0] RECALL_ADDR = 13'h0F0E,
    parameter int unsigned MIN_LOW     = 2,
    parameter int unsigned STORE_CYC   = 20,
    parameter int unsigned RECALL_CYC  = 12,
    parameter int unsigned PWRUP_CYC   = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    output logic          dq_oe,
    output logic          busy,
    output logic          op_store,
    output logic          op_done
);
    localparam int unsigned MAX_A = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int unsigned MAX_D = (MAX_A > PWRUP_CYC) ? MAX_A : PWRUP_CYC;
    localparam int unsigned CW    = $clog2(MAX_D + 1);
    localparam logic [4:0][AW-1:0] LEAD = {SEQ_A5, SEQ_A4, SEQ_A3, SEQ_A2, SEQ_A1};

    logic          evt, evt_ok;
    logic [AW-1:0] evt_addr;
    logic          go_store, go_recall;

    nvsr_pulse_mon #(.AW(AW), .MIN_LOW(MIN_LOW)) u_mon (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ce_n(ce_n), .we_n(we_n),
        .busy(busy), .evt(evt), .evt_ok(evt_ok), .evt_addr(evt_addr)
    );

    nvsr_seq #(.AW(AW), .LEAD_ADDR(LEAD), .STORE_ADDR(STORE_ADDR),
               .RECALL_ADDR(RECALL_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_ok(evt_ok), .evt_addr(evt_addr),
        .busy(busy), .go_store(go_store), .go_recall(go_recall)
    );

    nvsr_op_timer #(.CW(CW), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC),
                    .PWRUP_CYC(PWRUP_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .go_store(go_store), .go_recall(go_recall),
        .busy(busy), .op_store(op_store), .op_done(op_done)
    );

    assign dq_oe = !ce_n && !oe_n && we_n && !busy;

    // R8: the data bus is never driven during an operation
    p_hiz_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dq_oe);
    // R3: a STORE launch is followed by a busy STORE
    p_go_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_store |=> (busy && op_store));
    // R3: a RECALL launch is followed by a busy RECALL
    p_go_recall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_recall |=> (busy && !op_store));
endmodule

// File: tb/nvsr_ctrl_bench.sv
`timescale 1ns/1ps
module nvsr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STORE_CYC  = 20;
    localparam int RECALL_CYC = 12;
    localparam int PWRUP_CYC  = 30;
    localparam int MIN_LOW    = 2;

    localparam logic [12:0] A1 = 13'h0000, A2 = 13'h1555, A3 = 13'h0AAA,
                            A4 = 13'h1FFF, A5 = 13'h10F0,
                            AS = 13'h0F0F, AR = 13'h0F0E;

    // entry: {req[3:0], exp[1:0] (0 none,1 store,2 recall), width[3:0], we, addr[12:0]}
    function automatic logic [23:0] V(input logic [12:0] a, input logic we,
                                      input int w, input int ex, input int rq);
        return {4'(rq), 2'(ex), 4'(w), we, a};
    endfunction

    localparam int NV = 55;
    localparam logic [23:0] VEC [NV] = '{
        // R1 / R3: STORE, minimum width
        V(A1,1,2,0,1), V(A2,1,2,0,1), V(A3,1,2,0,1), V(A4,1,2,0,1), V(A5,1,2,0,1), V(AS,1,2,1,3),
        // R3 / R5: RECALL, wider pulses
        V(A1,1,3,0,5), V(A2,1,3,0,5), V(A3,1,3,0,5), V(A4,1,3,0,5), V(A5,1,3,0,5), V(AR,1,3,2,3),
        // R4: repeated address aborts, then full STORE
        V(A1,1,2,0,4), V(A2,1,2,0,4), V(A3,1,2,0,4), V(A3,1,2,0,4),
        V(A4,1,2,0,4), V(A5,1,2,0,4),
        V(A1,1,2,0,4), V(A2,1,2,0,4), V(A3,1,2,0,4), V(A4,1,2,0,4), V(A5,1,2,0,4), V(AS,1,2,1,4),
        // R2: write-enable low aborts, then full RECALL
        V(A1,1,2,0,2), V(A2,1,2,0,2), V(A3,0,2,0,2),
        V(A4,1,2,0,2), V(A5,1,2,0,2), V(AR,1,2,0,2),
        V(A1,1,2,0,2), V(A2,1,2,0,2), V(A3,1,2,0,2), V(A4,1,2,0,2), V(A5,1,2,0,2), V(AR,1,2,2,2),
        // R5: short glitch aborts
        V(A1,1,2,0,5), V(A2,1,2,0,5), V(A3,1,2,0,5), V(A4,1,1,0,5), V(A5,1,2,0,5), V(AS,1,2,0,5),
        // R4: mismatch at address 1 restarts at step one
        V(A1,1,2,0,4), V(A2,1,2,0,4), V(A1,1,2,0,4), V(A2,1,2,0,4), V(A3,1,2,0,4),
        V(A4,1,2,0,4), V(A5,1,2,0,4), V(AS,1,2,1,4),
        // R3: wrong sixth address starts nothing
        V(A1,1,2,0,3), V(A2,1,2,0,3), V(A3,1,2,0,3), V(A4,1,2,0,3), V(A5,1,2,0,3)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        dq_oe, busy, op_store, op_done;
    int          checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvsr_ctrl u_nvsr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .dq_oe(dq_oe), .busy(busy), .op_store(op_store), .op_done(op_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling clock edge; returns at the falling edge after the judging cycle.
    task automatic pulse(input logic [12:0] a, input logic we, input int w);
        bus_addr = a; we_n = we; ce_n = 1'b0;
        repeat (w) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    // At the falling edge after start; checks busy length and done pulse.
    task automatic run_op(input int dur, input bit st, input string req);
        chk(busy == 1'b1 && op_store == st, req, {busy, op_store}, {1'b1, st});
        repeat (dur - 1) @(negedge clk);
        chk(busy == 1'b1 && op_done == 1'b0, "R6 busy held", {busy, op_done}, 2'b10);
        @(negedge clk);
        chk(busy == 1'b0 && op_done == 1'b1, "R6 end+done", {busy, op_done}, 2'b01);
        @(negedge clk);
        chk(op_done == 1'b0, "R6 done single", op_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9: reset state, with E held low across the power-up recall (R7 coincidence)
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b1 && op_store == 1'b0, "R9 reset busy recall", {busy, op_store}, 2'b10);
        chk(dq_oe == 1'b0, "R8 no drive during power-up", dq_oe, 0);
        oe_n = 1'b1;
        repeat (PWRUP_CYC - 1) @(negedge clk);
        chk(busy == 1'b1, "R9 power-up length", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0 && op_done == 1'b1, "R9 power-up done", {busy, op_done}, 2'b01);
        ce_n = 1'b1;                       // judged as tracking resumes
        @(negedge clk);
        pulse(A2, 1, 2); pulse(A3, 1, 2); pulse(A4, 1, 2); pulse(A5, 1, 2); pulse(AS, 1, 2);
        chk(busy == 1'b0, "R7 straddling pulse ignored", busy, 0);

        // R8: idle read drives, output enable high does not
        bus_addr = A2; ce_n = 1'b0; oe_n = 1'b0; #1;
        chk(dq_oe == 1'b1, "R8 idle read drive", dq_oe, 1);
        oe_n = 1'b1; #1;
        chk(dq_oe == 1'b0, "R8 oe high", dq_oe, 0);
        we_n = 1'b0; oe_n = 1'b0; #1;
        chk(dq_oe == 1'b0, "R8 write no drive", dq_oe, 0);
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [23:0] e;
            e = VEC[i];
            pulse(e[12:0], e[13], int'(e[17:14]));
            if (e[19:18] == 2'd1)
                run_op(STORE_CYC, 1'b1, $sformatf("R%0d vec%0d store", e[23:20], i));
            else if (e[19:18] == 2'd2)
                run_op(RECALL_CYC, 1'b0, $sformatf("R%0d vec%0d recall", e[23:20], i));
            else
                chk(busy == 1'b0, $sformatf("R%0d vec%0d no start", e[23:20], i), busy, 0);
        end
        pulse(13'h1234, 1, 2);
        chk(busy == 1'b0, "R3 bad sixth address", busy, 0);

        // R2: output enable low throughout does not matter; R8 drive drop
        oe_n = 1'b0;
        pulse(A1, 1, 2); pulse(A2, 1, 2); pulse(A3, 1, 2); pulse(A4, 1, 2); pulse(A5, 1, 2);
        pulse(AS, 1, 2);
        chk(busy == 1'b1 && op_store == 1'b1, "R2 oe ignored store", {busy, op_store}, 2'b11);
        oe_n = 1'b1;

        // R7: pulses during busy ignored, sequence cleared after completion
        pulse(A1, 1, 2);
        ce_n = 1'b0; oe_n = 1'b0; #1;
        chk(dq_oe == 1'b0, "R8 hiz while busy", dq_oe, 0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        while (busy) @(negedge clk);
        pulse(A2, 1, 2); pulse(A3, 1, 2); pulse(A4, 1, 2); pulse(A5, 1, 2); pulse(AS, 1, 2);
        chk(busy == 1'b0, "R7 busy-time pulse ignored", busy, 0);

        // R1: fresh sequence after all that still works
        pulse(A1, 1, 2); pulse(A2, 1, 2); pulse(A3, 1, 2); pulse(A4, 1, 2); pulse(A5, 1, 2);
        pulse(AR, 1, 2);
        run_op(RECALL_CYC, 1'b0, "R1 final recall");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule